// File: doc/BRIEF.md
# Multi-Endpoint Buffer Pointer Controller

This block manages the address side of eight endpoint buffers, four for the transmit direction and four for the receive direction. The buffers themselves are external RAMs. All RAMs of one direction share a write-data bus, a write-address bus and a read-address bus. The block picks which RAM a write lands in by pulling that RAM's active-low write strobe. It picks which RAM is read through a select code. For each buffer it keeps a write position and a read position, and from them it derives full and empty flags.

Data moves in data sets. The writer appends bytes and then either closes the set (commit) or drops it (rewind). The reader walks the oldest closed set and can restart it to send or take it again (rewind). It then releases the set (commit), which frees the space. Buffers 0 to 2 of each direction are 64 entries deep and hold one closed set at a time. Buffer 3 of each direction is 512 entries deep and holds up to two closed sets, each with its own length. The receive side shows, for each buffer, whether a closed set is waiting.

Top module: `ep_fifo_ctrl`

## Requirements
- R1: After reset every buffer is empty and not full, `rx_pkt_rdy` and `tx_set_rdy` are 0, all write strobes are high, and the shared pointer buses read 0.
- R2: A write to a buffer that is not full pulls only strobe bit i low (bit i belongs to buffer i) in that cycle. The write-address bus shows that buffer's write position, the write-data bus carries the input byte, and the position advances by one.
- R3: The read select output equals the read buffer index as a 3-bit code (buffer i gives code i). The read-address bus shows that buffer's read position, and each accepted read advances it by one.
- R4: A 64-entry buffer is full while it holds 64 bytes, or while it holds one closed set that has not been released.
- R5: A buffer is empty unless its read position lies inside its oldest closed set. Bytes of a set that is still open are not readable.
- R6: A write to a full buffer and a read from an empty buffer change nothing: no strobe goes low and both positions stay put.
- R7: A write rewind moves the write position back to the start of the open set and drops its bytes.
- R8: A read rewind moves the read position back to the start of the current closed set without releasing it.
- R9: A read commit releases the oldest closed set. The read position jumps to its end, and its space and slot become free.
- R10: Buffer 3 (512 entries) holds two closed sets of different lengths. It reports full only when both slots are in use. Reads stop at the end of the first set, and the second set becomes readable after the first is released.
- R11: `rx_pkt_rdy[i]` is high exactly while receive buffer i holds at least one closed, unreleased set, and it rises only after a write commit to that buffer.
- R12: A write commit and a read commit to the same two-level buffer in one cycle both take effect. The slot count stays the same, and the new set becomes the oldest one once the old set is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Transmit: write one byte |
| tx_wr_idx | input | 2 | Transmit: buffer for write, write commit, write rewind |
| tx_wr_data | input | 8 | Transmit: byte to write |
| tx_wr_commit | input | 1 | Transmit: close the open set |
| tx_wr_rewind | input | 1 | Transmit: drop the open set |
| tx_rd_en | input | 1 | Transmit: read one byte |
| tx_rd_idx | input | 2 | Transmit: buffer for read, read commit, read rewind |
| tx_rd_commit | input | 1 | Transmit: release the oldest set |
| tx_rd_rewind | input | 1 | Transmit: restart the current set |
| rx_wr_en | input | 1 | Receive: write one byte |
| rx_wr_idx | input | 2 | Receive: buffer for write-side operations |
| rx_wr_data | input | 8 | Receive: byte to write |
| rx_wr_commit | input | 1 | Receive: close the open set |
| rx_wr_rewind | input | 1 | Receive: drop the open set |
| rx_rd_en | input | 1 | Receive: read one byte |
| rx_rd_idx | input | 2 | Receive: buffer for read-side operations |
| rx_rd_commit | input | 1 | Receive: release the oldest set |
| rx_rd_rewind | input | 1 | Receive: restart the current set |
| tx_full | output | 4 | Transmit full flags, bit per buffer |
| tx_empty | output | 4 | Transmit empty flags |
| tx_set_rdy | output | 4 | Transmit buffer holds a closed set |
| tx_ram_wdata | output | 8 | Shared transmit RAM write data |
| tx_ram_wptr | output | 9 | Shared transmit RAM write address |
| tx_ram_rptr | output | 9 | Shared transmit RAM read address |
| tx_ram_wr_n | output | 4 | Transmit RAM write strobes, active low |
| tx_ram_sel | output | 3 | Transmit RAM read select code |
| rx_full | output | 4 | Receive full flags |
| rx_empty | output | 4 | Receive empty flags |
| rx_pkt_rdy | output | 4 | Receive buffer holds a closed set |
| rx_ram_wdata | output | 8 | Shared receive RAM write data |
| rx_ram_wptr | output | 9 | Shared receive RAM write address |
| rx_ram_rptr | output | 9 | Shared receive RAM read address |
| rx_ram_wr_n | output | 4 | Receive RAM write strobes, active low |
| rx_ram_sel | output | 3 | Receive RAM read select code |

## Verification
The write-side commit and the read-side release can land on the same two-level buffer in the same cycle. Both change the slot count and the stored lengths. The bench fills receive buffer 3 with two sets and releases one. It then writes a fresh set and raises both commits together. The result is judged by the read position jumping to the end of the released set, the flags showing one slot used, and a further commit then making the buffer full.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  localparam int DATA_W      = 8;
  localparam int PTR_W       = 9;
  localparam int NBUF        = 4;
  localparam int SEL_W       = 3;
  localparam int SMALL_DEPTH = 64;
  localparam int LARGE_DEPTH = 512;
  localparam int LARGE_IDX   = 3;
  localparam int LARGE_SETS  = 2;
endpackage

// File: rtl/ep_buf_ptr.sv
module ep_buf_ptr #(
  parameter int DEPTH  = 64,
  parameter int LEVELS = 1,
  parameter int PTR_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_commit,
  input  logic             wr_rewind,
  input  logic             rd_en,
  input  logic             rd_commit,
  input  logic             rd_rewind,
  output logic             full,
  output logic             empty,
  output logic             ready,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(LEVELS + 1);
  typedef logic [AW:0] ptr_t;

  ptr_t          wptr_q, wptr_d, wend_q, wend_d;
  ptr_t          rptr_q, rptr_d, rstart_q, rstart_d;
  logic [SW-1:0] slots_q, slots_d, base;
  ptr_t          len_q [LEVELS];
  ptr_t          len_d [LEVELS];
  ptr_t          used, rd_lim, wptr_inc, new_len;
  logic          do_wr, do_rd, do_wc, do_rc, en;

  // flags and accepted operations
  always_comb begin
    used   = wptr_q - rstart_q;
    rd_lim = rstart_q + len_q[0];
    ready  = (slots_q != '0);
    full   = (slots_q == SW'(LEVELS)) || (used == ptr_t'(DEPTH));
    empty  = !ready || (rptr_q == rd_lim);
    do_wr  = wr_en && !full;
    do_rd  = rd_en && !empty;
    do_wc  = wr_commit && (slots_q != SW'(LEVELS));
    do_rc  = rd_commit && ready;
    en     = wr_en || wr_commit || wr_rewind || rd_en || rd_commit || rd_rewind;
  end

  // next state: commit outranks rewind, rewind outranks a byte step
  always_comb begin
    wptr_inc = wptr_q + ptr_t'(do_wr);
    new_len  = wptr_inc - wend_q;
    wptr_d   = do_wc ? wptr_inc : (wr_rewind ? wend_q : wptr_inc);
    wend_d   = do_wc ? wptr_inc : wend_q;
    rptr_d   = do_rc ? rd_lim : (rd_rewind ? rstart_q : rptr_q + ptr_t'(do_rd));
    rstart_d = do_rc ? rd_lim : rstart_q;
    base     = slots_q - SW'(do_rc);
    slots_d  = slots_q + SW'(do_wc) - SW'(do_rc);
    for (int k = 0; k < LEVELS; k++) begin
      len_d[k] = do_rc ? len_q[(k + 1 < LEVELS) ? k + 1 : k] : len_q[k];
      if (do_wc && (SW'(k) == base)) len_d[k] = new_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      wend_q   <= '0;
      rptr_q   <= '0;
      rstart_q <= '0;
      slots_q  <= '0;
      len_q    <= '{default: '0};
    end else if (en) begin
      wptr_q   <= wptr_d;
      wend_q   <= wend_d;
      rptr_q   <= rptr_d;
      rstart_q <= rstart_d;
      slots_q  <= slots_d;
      len_q    <= len_d;
    end
  end

  assign wptr_o = PTR_W'(wptr_q[AW-1:0]);
  assign rptr_o = PTR_W'(rptr_q[AW-1:0]);
endmodule

// File: rtl/ep_dir_ctrl.sv
module ep_dir_ctrl #(
  parameter int NBUF        = 4,
  parameter int SMALL_DEPTH = 64,
  parameter int LARGE_DEPTH = 512,
  parameter int LARGE_IDX   = 3,
  parameter int LARGE_SETS  = 2,
  parameter int PTR_W       = 9,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 3,
  parameter int IW          = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              wr_rewind,
  input  logic              rd_en,
  input  logic [IW-1:0]     rd_idx,
  input  logic              rd_commit,
  input  logic              rd_rewind,
  output logic [NBUF-1:0]   full,
  output logic [NBUF-1:0]   empty,
  output logic [NBUF-1:0]   ready,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [PTR_W-1:0]  ram_wptr,
  output logic [PTR_W-1:0]  ram_rptr,
  output logic [NBUF-1:0]   ram_wr_n,
  output logic [SEL_W-1:0]  ram_sel
);
  logic [PTR_W-1:0] wptr_all [NBUF];
  logic [PTR_W-1:0] rptr_all [NBUF];

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    logic wsel, rsel;
    assign wsel = (wr_idx == IW'(i));
    assign rsel = (rd_idx == IW'(i));

    ep_buf_ptr #(
      .DEPTH ((i == LARGE_IDX) ? LARGE_DEPTH : SMALL_DEPTH),
      .LEVELS((i == LARGE_IDX) ? LARGE_SETS : 1),
      .PTR_W (PTR_W)
    ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && wsel),
      .wr_commit(wr_commit && wsel),
      .wr_rewind(wr_rewind && wsel),
      .rd_en    (rd_en && rsel),
      .rd_commit(rd_commit && rsel),
      .rd_rewind(rd_rewind && rsel),
      .full     (full[i]),
      .empty    (empty[i]),
      .ready    (ready[i]),
      .wptr_o   (wptr_all[i]),
      .rptr_o   (rptr_all[i])
    );

    assign ram_wr_n[i] = !(wr_en && wsel && !full[i]);
  end

  assign ram_wdata = wr_data;
  assign ram_wptr  = wptr_all[wr_idx];
  assign ram_rptr  = rptr_all[rd_idx];
  assign ram_sel   = SEL_W'(rd_idx);
endmodule

// File: rtl/ep_fifo_ctrl.sv
module ep_fifo_ctrl
  import ep_fifo_pkg::*;
#(
  parameter int NB  = NBUF,
  parameter int DW  = DATA_W,
  parameter int PW  = PTR_W,
  parameter int SW  = SEL_W,
  parameter int IW  = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr_en,
  input  logic [IW-1:0] tx_wr_idx,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          tx_wr_commit,
  input  logic          tx_wr_rewind,
  input  logic          tx_rd_en,
  input  logic [IW-1:0] tx_rd_idx,
  input  logic          tx_rd_commit,
  input  logic          tx_rd_rewind,
  input  logic          rx_wr_en,
  input  logic [IW-1:0] rx_wr_idx,
  input  logic [DW-1:0] rx_wr_data,
  input  logic          rx_wr_commit,
  input  logic          rx_wr_rewind,
  input  logic          rx_rd_en,
  input  logic [IW-1:0] rx_rd_idx,
  input  logic          rx_rd_commit,
  input  logic          rx_rd_rewind,
  output logic [NB-1:0] tx_full,
  output logic [NB-1:0] tx_empty,
  output logic [NB-1:0] tx_set_rdy,
  output logic [DW-1:0] tx_ram_wdata,
  output logic [PW-1:0] tx_ram_wptr,
  output logic [PW-1:0] tx_ram_rptr,
  output logic [NB-1:0] tx_ram_wr_n,
  output logic [SW-1:0] tx_ram_sel,
  output logic [NB-1:0] rx_full,
  output logic [NB-1:0] rx_empty,
  output logic [NB-1:0] rx_pkt_rdy,
  output logic [DW-1:0] rx_ram_wdata,
  output logic [PW-1:0] rx_ram_wptr,
  output logic [PW-1:0] rx_ram_rptr,
  output logic [NB-1:0] rx_ram_wr_n,
  output logic [SW-1:0] rx_ram_sel
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ep_dir_ctrl #(
    .NBUF(NB), .SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH),
    .LARGE_IDX(LARGE_IDX), .LARGE_SETS(LARGE_SETS), .PTR_W(PW),
    .DATA_W(DW), .SEL_W(SW), .IW(IW)
  ) u_tx (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(tx_wr_en), .wr_idx(tx_wr_idx), .wr_data(tx_wr_data),
    .wr_commit(tx_wr_commit), .wr_rewind(tx_wr_rewind),
    .rd_en(tx_rd_en), .rd_idx(tx_rd_idx),
    .rd_commit(tx_rd_commit), .rd_rewind(tx_rd_rewind),
    .full(tx_full), .empty(tx_empty), .ready(tx_set_rdy),
    .ram_wdata(tx_ram_wdata), .ram_wptr(tx_ram_wptr), .ram_rptr(tx_ram_rptr),
    .ram_wr_n(tx_ram_wr_n), .ram_sel(tx_ram_sel)
  );

  ep_dir_ctrl #(
    .NBUF(NB), .SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH),
    .LARGE_IDX(LARGE_IDX), .LARGE_SETS(LARGE_SETS), .PTR_W(PW),
    .DATA_W(DW), .SEL_W(SW), .IW(IW)
  ) u_rx (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(rx_wr_en), .wr_idx(rx_wr_idx), .wr_data(rx_wr_data),
    .wr_commit(rx_wr_commit), .wr_rewind(rx_wr_rewind),
    .rd_en(rx_rd_en), .rd_idx(rx_rd_idx),
    .rd_commit(rx_rd_commit), .rd_rewind(rx_rd_rewind),
    .full(rx_full), .empty(rx_empty), .ready(rx_pkt_rdy),
    .ram_wdata(rx_ram_wdata), .ram_wptr(rx_ram_wptr), .ram_rptr(rx_ram_rptr),
    .ram_wr_n(rx_ram_wr_n), .ram_sel(rx_ram_sel)
  );
endmodule

// File: rtl/ep_fifo_ctrl_chk.sv
module ep_fifo_ctrl_chk #(
  parameter int NB = 4,
  parameter int PW = 9,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] tx_ram_wr_n,
  input logic [NB-1:0] rx_ram_wr_n,
  input logic [NB-1:0] tx_full,
  input logic [NB-1:0] rx_full,
  input logic [NB-1:0] rx_empty,
  input logic [NB-1:0] rx_pkt_rdy,
  input logic          rx_wr_en,
  input logic [IW-1:0] rx_wr_idx,
  input logic          rx_wr_commit,
  input logic          rx_wr_rewind,
  input logic [PW-1:0] rx_ram_wptr,
  input logic          tx_rd_en,
  input logic [IW-1:0] tx_rd_idx,
  input logic          tx_rd_commit,
  input logic          tx_rd_rewind,
  input logic [NB-1:0] tx_empty,
  input logic [PW-1:0] tx_ram_rptr
);
  // R2
  tx_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~tx_ram_wr_n));
  // R2
  rx_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rx_ram_wr_n));
  // R6
  no_strobe_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tx_ram_wr_n & tx_full) == '0) && ((~rx_ram_wr_n & rx_full) == '0));
  // R6
  full_write_holds_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_en && rx_full[rx_wr_idx] && !rx_wr_commit && !rx_wr_rewind)
    |=> (rx_ram_wptr == $past(rx_ram_wptr)) || (rx_wr_idx != $past(rx_wr_idx)));
  // R6
  empty_read_holds_rptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rd_en && tx_empty[tx_rd_idx] && !tx_rd_commit && !tx_rd_rewind)
    |=> (tx_ram_rptr == $past(tx_ram_rptr)) || (tx_rd_idx != $past(tx_rd_idx)));

  for (genvar i = 0; i < NB; i++) begin : g_buf_chk
    // R11
    ready_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_pkt_rdy[i]) |-> $past(rx_wr_commit && (rx_wr_idx == IW'(i))));
    // R5
    not_ready_is_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_pkt_rdy[i] |-> rx_empty[i]);
  end
endmodule

bind ep_fifo_ctrl ep_fifo_ctrl_chk #(.NB(NB), .PW(PW), .IW(IW)) u_chk (.*);

// File: tb/ep_fifo_ctrl_bench.sv
module ep_fifo_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_wr_en, tx_wr_commit, tx_wr_rewind, tx_rd_en, tx_rd_commit, tx_rd_rewind;
  logic       rx_wr_en, rx_wr_commit, rx_wr_rewind, rx_rd_en, rx_rd_commit, rx_rd_rewind;
  logic [1:0] tx_wr_idx, tx_rd_idx, rx_wr_idx, rx_rd_idx;
  logic [7:0] tx_wr_data, rx_wr_data;
  logic [3:0] tx_full, tx_empty, tx_set_rdy, tx_ram_wr_n;
  logic [3:0] rx_full, rx_empty, rx_pkt_rdy, rx_ram_wr_n;
  logic [7:0] tx_ram_wdata, rx_ram_wdata;
  logic [8:0] tx_ram_wptr, tx_ram_rptr, rx_ram_wptr, rx_ram_rptr;
  logic [2:0] tx_ram_sel, rx_ram_sel;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ep_fifo_ctrl u_ep_fifo_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rxw(input int idx, input int n, input int exp_n, input string req);
    rx_wr_idx = 2'(idx); rx_wr_data = 8'(8'h40 + idx); rx_wr_en = 1'b1;
    #1;
    check({req, " rx strobe"}, rx_ram_wr_n, exp_n);
    check({req, " rx wdata"}, rx_ram_wdata, 8'h40 + idx);
    repeat (n) @(negedge clk);
    rx_wr_en = 1'b0;
  endtask

  task automatic txw(input int idx, input int n, input int exp_n, input string req);
    tx_wr_idx = 2'(idx); tx_wr_data = 8'(8'h90 + idx); tx_wr_en = 1'b1;
    #1;
    check({req, " tx strobe"}, tx_ram_wr_n, exp_n);
    repeat (n) @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic rxr(input int idx, input int n);
    rx_rd_idx = 2'(idx); rx_rd_en = 1'b1;
    repeat (n) @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  task automatic txr(input int idx, input int n);
    tx_rd_idx = 2'(idx); tx_rd_en = 1'b1;
    repeat (n) @(negedge clk);
    tx_rd_en = 1'b0;
  endtask

  // one-cycle pulse: 0 wcommit, 1 wrewind, 2 rcommit, 3 rrewind
  task automatic rx_op(input int kind);
    case (kind)
      0: rx_wr_commit = 1'b1;
      1: rx_wr_rewind = 1'b1;
      2: rx_rd_commit = 1'b1;
      default: rx_rd_rewind = 1'b1;
    endcase
    @(negedge clk);
    {rx_wr_commit, rx_wr_rewind, rx_rd_commit, rx_rd_rewind} = '0;
  endtask

  task automatic tx_op(input int kind);
    case (kind)
      0: tx_wr_commit = 1'b1;
      1: tx_wr_rewind = 1'b1;
      2: tx_rd_commit = 1'b1;
      default: tx_rd_rewind = 1'b1;
    endcase
    @(negedge clk);
    {tx_wr_commit, tx_wr_rewind, tx_rd_commit, tx_rd_rewind} = '0;
  endtask

  task automatic t_reset;
    check("R1 rx_empty", rx_empty, 4'hF);
    check("R1 tx_empty", tx_empty, 4'hF);
    check("R1 full", {tx_full, rx_full}, 0);
    check("R1 ready", {tx_set_rdy, rx_pkt_rdy}, 0);
    check("R1 strobes", {tx_ram_wr_n, rx_ram_wr_n}, 8'hFF);
    check("R1 pointers", {tx_ram_wptr, tx_ram_rptr, rx_ram_wptr, rx_ram_rptr}, 0);
  endtask

  task automatic t_single_set;
    rxw(1, 5, 4'b1101, "R2");
    check("R2 wptr", rx_ram_wptr, 5);
    check("R5 open set unreadable", rx_empty[1], 1);
    check("R11 no ready before commit", rx_pkt_rdy[1], 0);
    rx_wr_idx = 2'd1; rx_op(0);
    check("R11 ready", rx_pkt_rdy, 4'b0010);
    check("R5 not empty", rx_empty[1], 0);
    check("R4 full after commit", rx_full[1], 1);
    rx_rd_idx = 2'd1; #1;
    check("R3 sel", rx_ram_sel, 1);
    check("R3 rptr start", rx_ram_rptr, 0);
    rxr(1, 5);
    check("R3 rptr", rx_ram_rptr, 5);
    check("R5 empty at set end", rx_empty[1], 1);
    rxr(1, 1);
    check("R6 empty read ignored", rx_ram_rptr, 5);
    rx_op(2);
    check("R9 released ready", rx_pkt_rdy[1], 0);
    check("R9 released full", rx_full[1], 0);
    check("R9 rptr", rx_ram_rptr, 5);
  endtask

  task automatic t_rewind;
    txw(2, 3, 4'b1011, "R2");
    check("R2 tx wptr", tx_ram_wptr, 3);
    tx_wr_idx = 2'd2; tx_op(1);
    check("R7 wptr back", tx_ram_wptr, 0);
    check("R7 nothing closed", tx_set_rdy[2], 0);
    txw(2, 2, 4'b1011, "R2");
    tx_op(0);
    check("R7 wptr after commit", tx_ram_wptr, 2);
    tx_rd_idx = 2'd2; #1;
    check("R3 tx sel", tx_ram_sel, 2);
    txr(2, 1);
    check("R3 tx rptr", tx_ram_rptr, 1);
    tx_op(3);
    check("R8 rptr back", tx_ram_rptr, 0);
    txr(2, 3);
    check("R8 reread stops at end", tx_ram_rptr, 2);
    check("R5 tx empty", tx_empty[2], 1);
    tx_op(3);
    check("R8 rewind keeps set", tx_empty[2], 0);
    check("R8 set still held", tx_set_rdy[2], 1);
    tx_op(2);
    check("R9 tx rptr", tx_ram_rptr, 2);
    check("R9 tx released", tx_set_rdy[2], 0);
  endtask

  task automatic t_fill;
    rxw(0, 64, 4'b1110, "R2");
    check("R4 full at 64", rx_full[0], 1);
    check("R4 wptr wraps", rx_ram_wptr, 0);
    rxw(0, 1, 4'b1111, "R6");
    check("R6 full write ignored", rx_ram_wptr, 0);
    check("R6 still full", rx_full[0], 1);
    rx_op(1);
    check("R7 rewind frees", rx_full[0], 0);
  endtask

  task automatic t_two_level;
    rxw(3, 3, 4'b0111, "R2");
    rx_wr_idx = 2'd3; rx_op(0);
    check("R10 one slot not full", rx_full[3], 0);
    check("R11 ready 3", rx_pkt_rdy[3], 1);
    rxw(3, 5, 4'b0111, "R2");
    check("R10 wptr", rx_ram_wptr, 8);
    rx_op(0);
    check("R10 two slots full", rx_full[3], 1);
    rxw(3, 1, 4'b1111, "R6");
    check("R6 wptr held", rx_ram_wptr, 8);
    rx_rd_idx = 2'd3; #1;
    check("R3 sel 3", rx_ram_sel, 3);
    rxr(3, 4);
    check("R10 stops at first set", rx_ram_rptr, 3);
    check("R10 empty at first end", rx_empty[3], 1);
    rx_op(2);
    check("R10 second readable", rx_empty[3], 0);
    check("R9 slot freed", rx_full[3], 0);
    rxw(3, 2, 4'b0111, "R2");
    check("R12 wptr", rx_ram_wptr, 10);
    rx_wr_commit = 1'b1; rx_rd_commit = 1'b1;
    @(negedge clk);
    rx_wr_commit = 1'b0; rx_rd_commit = 1'b0;
    check("R12 rptr to released end", rx_ram_rptr, 8);
    check("R12 one slot", rx_full[3], 0);
    check("R12 ready", rx_pkt_rdy[3], 1);
    rxr(3, 3);
    check("R12 new set length", rx_ram_rptr, 10);
    rxw(3, 1, 4'b0111, "R2");
    rx_op(0);
    check("R12 second slot fills", rx_full[3], 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {tx_wr_en, tx_wr_commit, tx_wr_rewind, tx_rd_en, tx_rd_commit, tx_rd_rewind} = '0;
    {rx_wr_en, rx_wr_commit, rx_wr_rewind, rx_rd_en, rx_rd_commit, rx_rd_rewind} = '0;
    {tx_wr_idx, tx_rd_idx, rx_wr_idx, rx_rd_idx} = '0;
    tx_wr_data = '0; rx_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_set();
    t_rewind();
    t_fill();
    t_two_level();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule